// File: doc/BRIEF.md
# Flow Classifier Init Sequencer

This block brings up a hardware flow-classification table after a single start pulse. The table needs memory, so the sequencer first takes that memory out of receive packet buffer 0. It reads that buffer's size register, subtracts the table footprint and writes the smaller value back. It then writes zero to the size registers of buffers 1 to 7, so that their nonzero reset values cannot overlap the carved region.

Next it loads the bucket hash key and then the signature hash key. It writes the control word and issues one dummy read, which forces all earlier writes to land. It then reads the control register again and again to look for the init-done flag. The reads are spaced by a fixed number of clock cycles, and their count has an upper limit. The sequence ends with a done pulse, plus a timeout flag if the flag never appeared.

All register traffic goes through one request/acknowledge master port. That port carries one access at a time.

Top module: `flow_table_init_seq`

## Requirements
- R1: The allocation code selects the table size: 1 = 64 KiB, 2 = 128 KiB, 3 = 256 KiB. Code 0 is rejected. A start with code 0 gives an `error_o` pulse one cycle later, `busy_o` stays low and no bus request is issued.
- R2: The first access reads the buffer-0 size register at `BUF_BASE`. The second access writes that value minus 2^(15+code) back to the same address.
- R3: The sequencer then writes zero to the size registers of buffers 1 to 7, in ascending order, at `BUF_BASE + 4*i`.
- R4: After the buffer writes come three writes in this order: the bucket key to `BKEY_ADDR`, then the signature key to `SKEY_ADDR`, then the control word to `CTRL_ADDR`.
- R5: The control word holds the allocation code in bits 1:0, 0xA in bits 27:24 (longest bucket chain) and 4 in bits 31:28 (fill-warning level). All other bits are zero.
- R6: After the control write, one read of `FLUSH_ADDR` is issued. Every later access is a read of `CTRL_ADDR`, and bit 3 of the returned data is the init-done flag.
- R7: Consecutive polls are at least `POLL_CYCLES` clock cycles apart. No more than `POLL_LIMIT` polls are issued.
- R8: A poll that returns init-done set ends the sequence with a one-cycle `done_o` pulse, with `timeout_o` low.
- R9: If the last allowed poll still returns init-done clear, `done_o` pulses with `timeout_o` high. `timeout_o` then stays high until the next accepted start.
- R10: `bus_req_o` stays high, with address, data and direction stable, until `bus_ack_i` is seen. It drops in the cycle after the acknowledge.
- R11: `busy_o` rises the cycle after an accepted start and falls when `done_o` pulses. A start that arrives while busy has no effect on the access sequence or on the result.
- R12: Out of reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to run the bring-up |
| alloc_code_i | input | 2 | Table size code, sampled with `start_i` |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Access address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access complete; read data valid |
| bus_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| timeout_o | output | 1 | Init-done never seen; held until the next start |
| error_o | output | 1 | One-cycle pulse for a rejected code |

## Verification
- `busy_o` and `error_o` are registered, so both are due one cycle after the start edge. The bench samples them on the falling edge that follows.
- Bus results depend on the responder's acknowledge latency, which the bench varies from zero to two cycles per run. For that reason, the bench does not count a fixed number of cycles for the bus results. It logs every acknowledged access with its cycle number and checks the order, the data and the spacing between polls after `done_o`.
- `done_o` lasts only one cycle. The bench watches for it on every falling edge and checks `timeout_o` and `busy_o` on that same edge.

// File: rtl/fci_pkg.sv
package fci_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_BUF0,
        S_WR_BUF0,
        S_CLR_BUF,
        S_WR_BKEY,
        S_WR_SKEY,
        S_WR_CTRL,
        S_FLUSH,
        S_POLL_RD,
        S_POLL_WAIT
    } fci_state_e;

    // Codes 1..3 select a table size; code 0 has no size and is refused.
    function automatic logic fci_code_ok(input logic [1:0] code);
        return code != 2'd0;
    endfunction

endpackage

// File: rtl/fci_word_builder.sv
module fci_word_builder #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SHIFT_BASE = 15,
    parameter int unsigned FIELD_W    = 4,
    parameter int unsigned MAXLEN_LSB = 24,
    parameter int unsigned THRESH_LSB = 28,
    parameter logic [3:0]  MAXLEN_VAL = 4'hA,
    parameter logic [3:0]  THRESH_VAL = 4'h4
) (
    input  logic [1:0]        code_i,
    input  logic [DATA_W-1:0] buf0_size_i,
    output logic [DATA_W-1:0] shrunk_size_o,
    output logic [DATA_W-1:0] ctrl_word_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] carve;

    always_comb begin
        carve         = ONE << (SHIFT_BASE + 32'(code_i));
        shrunk_size_o = buf0_size_i - carve;
    end

    always_comb begin
        ctrl_word_o                           = '0;
        ctrl_word_o[1:0]                      = code_i;
        ctrl_word_o[MAXLEN_LSB +: FIELD_W]    = MAXLEN_VAL[FIELD_W-1:0];
        ctrl_word_o[THRESH_LSB +: FIELD_W]    = THRESH_VAL[FIELD_W-1:0];
    end

endmodule

// File: rtl/fci_tick_timer.sv
module fci_tick_timer #(
    parameter int unsigned CYCLES = 100000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expired_o
);

    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = run_i && (cnt_q == CNT_W'(CYCLES - 1));
        if (!run_i || expired_o) cnt_d = '0;
        else                     cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/flow_table_init_seq.sv
module flow_table_init_seq
    import fci_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       NUM_BUFS    = 8,
    parameter int unsigned       BUF_STRIDE  = 4,
    parameter logic [ADDR_W-1:0] BUF_BASE    = 32'h0000_3C00,
    parameter logic [ADDR_W-1:0] BKEY_ADDR   = 32'h0000_EE68,
    parameter logic [ADDR_W-1:0] SKEY_ADDR   = 32'h0000_EE6C,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 32'h0000_EE00,
    parameter logic [ADDR_W-1:0] FLUSH_ADDR  = 32'h0000_0008,
    parameter logic [DATA_W-1:0] BKEY_VAL    = 32'hA5C3_0F1E,
    parameter logic [DATA_W-1:0] SKEY_VAL    = 32'h5A3C_F0E1,
    parameter int unsigned       DONE_BIT    = 3,
    parameter int unsigned       POLL_CYCLES = 100000,
    parameter int unsigned       POLL_LIMIT  = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        alloc_code_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              error_o
);

    localparam int unsigned IDX_W  = $clog2(NUM_BUFS);
    localparam int unsigned POLL_W = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        fci_state_e        state;
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [IDX_W-1:0]  idx;
        logic [POLL_W-1:0] polls;
        logic [1:0]        code;
        logic [DATA_W-1:0] buf0;
        logic              done;
        logic              timeout;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [DATA_W-1:0] shrunk_w, ctrl_w;
    logic              tick_w;
    logic              acc_en, acc_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic [POLL_W-1:0] polls_inc;

    fci_word_builder #(
        .DATA_W (DATA_W)
    ) u_words (
        .code_i        (seq_q.code),
        .buf0_size_i   (seq_q.buf0),
        .shrunk_size_o (shrunk_w),
        .ctrl_word_o   (ctrl_w)
    );

    fci_tick_timer #(
        .CYCLES (POLL_CYCLES)
    ) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (seq_q.state == S_POLL_WAIT),
        .expired_o (tick_w)
    );

    // What the current state puts on the bus.
    always_comb begin
        acc_en    = 1'b1;
        acc_we    = 1'b1;
        acc_addr  = '0;
        acc_wdata = '0;
        unique case (seq_q.state)
            S_RD_BUF0: begin acc_we = 1'b0; acc_addr = BUF_BASE; end
            S_WR_BUF0: begin acc_addr = BUF_BASE; acc_wdata = shrunk_w; end
            S_CLR_BUF: acc_addr = BUF_BASE + ADDR_W'(seq_q.idx) * ADDR_W'(BUF_STRIDE);
            S_WR_BKEY: begin acc_addr = BKEY_ADDR; acc_wdata = BKEY_VAL; end
            S_WR_SKEY: begin acc_addr = SKEY_ADDR; acc_wdata = SKEY_VAL; end
            S_WR_CTRL: begin acc_addr = CTRL_ADDR; acc_wdata = ctrl_w; end
            S_FLUSH:   begin acc_we = 1'b0; acc_addr = FLUSH_ADDR; end
            S_POLL_RD: begin acc_we = 1'b0; acc_addr = CTRL_ADDR; end
            default:   acc_en = 1'b0;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        polls_inc  = seq_q.polls + POLL_W'(1);

        if (seq_q.state == S_IDLE) begin
            if (start_i) begin
                if (fci_code_ok(alloc_code_i)) begin
                    seq_d.state   = S_RD_BUF0;
                    seq_d.code    = alloc_code_i;
                    seq_d.timeout = 1'b0;
                    seq_d.polls   = '0;
                end else begin
                    seq_d.err = 1'b1;
                end
            end
        end else if (seq_q.state == S_POLL_WAIT) begin
            if (tick_w) seq_d.state = S_POLL_RD;
        end else if (acc_en) begin
            if (!seq_q.req) begin
                seq_d.req   = 1'b1;
                seq_d.we    = acc_we;
                seq_d.addr  = acc_addr;
                seq_d.wdata = acc_wdata;
            end else if (bus_ack_i) begin
                seq_d.req = 1'b0;
                unique case (seq_q.state)
                    S_RD_BUF0: begin
                        seq_d.buf0  = bus_rdata_i;
                        seq_d.state = S_WR_BUF0;
                    end
                    S_WR_BUF0: begin
                        seq_d.idx   = IDX_W'(1);
                        seq_d.state = S_CLR_BUF;
                    end
                    S_CLR_BUF: begin
                        if (seq_q.idx == IDX_W'(NUM_BUFS - 1)) seq_d.state = S_WR_BKEY;
                        else seq_d.idx = seq_q.idx + IDX_W'(1);
                    end
                    S_WR_BKEY: seq_d.state = S_WR_SKEY;
                    S_WR_SKEY: seq_d.state = S_WR_CTRL;
                    S_WR_CTRL: seq_d.state = S_FLUSH;
                    S_FLUSH:   seq_d.state = S_POLL_RD;
                    S_POLL_RD: begin
                        seq_d.polls = polls_inc;
                        if (bus_rdata_i[DONE_BIT]) begin
                            seq_d.state = S_IDLE;
                            seq_d.done  = 1'b1;
                        end else if (polls_inc == POLL_W'(POLL_LIMIT)) begin
                            seq_d.state   = S_IDLE;
                            seq_d.done    = 1'b1;
                            seq_d.timeout = 1'b1;
                        end else begin
                            seq_d.state = S_POLL_WAIT;
                        end
                    end
                    default: seq_d.state = S_IDLE;
                endcase
            end
        end else begin
            seq_d.state = S_IDLE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q       <= '0;
            seq_q.state <= S_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_req_o   = seq_q.req;
    assign bus_we_o    = seq_q.we;
    assign bus_addr_o  = seq_q.addr;
    assign bus_wdata_o = seq_q.wdata;
    assign busy_o      = seq_q.state != S_IDLE;
    assign done_o      = seq_q.done;
    assign timeout_o   = seq_q.timeout;
    assign error_o     = seq_q.err;

endmodule

// File: rtl/fci_init_checker.sv
module fci_init_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              timeout_o,
    input logic              error_o
);

    // R10: an open request keeps its contents until acknowledged
    a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                    && $stable(bus_wdata_o) && $stable(bus_we_o));

    // R10: request withdrawn right after acknowledge
    a_r10_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && bus_ack_i |=> !bus_req_o);

    // R11: no bus traffic while idle
    a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !bus_req_o);

    // R8: done closes a busy period
    a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o && $past(busy_o));

    // R1: a refusal never comes with activity
    a_r1_error_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |-> !busy_o && !bus_req_o && !done_o);

    // R9: timeout flag only appears together with done
    a_r9_timeout_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> done_o);

endmodule

bind flow_table_init_seq fci_init_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_fci_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .error_o     (error_o)
);

// File: tb/test_flow_table_init_seq.sv
module test_flow_table_init_seq;

    localparam int POLL_CYCLES = 20;
    localparam int POLL_LIMIT  = 4;
    localparam logic [31:0] BUF_BASE   = 32'h0000_3C00;
    localparam logic [31:0] BKEY_ADDR  = 32'h0000_EE68;
    localparam logic [31:0] SKEY_ADDR  = 32'h0000_EE6C;
    localparam logic [31:0] CTRL_ADDR  = 32'h0000_EE00;
    localparam logic [31:0] FLUSH_ADDR = 32'h0000_0008;
    localparam logic [31:0] BKEY_VAL   = 32'hA5C3_0F1E;
    localparam logic [31:0] SKEY_VAL   = 32'h5A3C_F0E1;

    // stimulus / expectation table: code, buffer-0 size, poll that sees done, ack latency
    localparam int NV = 4;
    localparam int          V_CODE [NV] = '{1, 2, 3, 1};
    localparam logic [31:0] V_BUF0 [NV] = '{32'h0004_0000, 32'h0008_0000, 32'h000A_0000, 32'h0002_0000};
    localparam int          V_DONE [NV] = '{1, 3, 4, 9};
    localparam int          V_LAT  [NV] = '{0, 1, 2, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] code = 2'd0;
    logic req, we, ack, busy, done, tmo, err;
    logic [31:0] addr, wdata, rdata;

    always #5 clk = ~clk;

    flow_table_init_seq #(
        .POLL_CYCLES (POLL_CYCLES),
        .POLL_LIMIT  (POLL_LIMIT)
    ) i_flow_table_init_seq (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .alloc_code_i (code),
        .bus_req_o    (req),
        .bus_we_o     (we),
        .bus_addr_o   (addr),
        .bus_wdata_o  (wdata),
        .bus_ack_i    (ack),
        .bus_rdata_i  (rdata),
        .busy_o       (busy),
        .done_o       (done),
        .timeout_o    (tmo),
        .error_o      (err)
    );

    // ---------------- register responder with access log ----------------
    int          cyc = 0;
    int          lat_cfg = 0;
    logic [31:0] buf0_init = '0;
    int          done_thresh = 1;
    int          lat_cnt = 0;
    int          ctrl_rd_n = 0;
    int          log_n = 0;
    int          done_cnt = 0;
    int          err_cnt = 0;
    logic [31:0] lg_addr [256];
    logic [31:0] lg_data [256];
    logic        lg_we   [256];
    int          lg_cyc  [256];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (err)  err_cnt  <= err_cnt + 1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            rdata <= '0;
            lat_cnt <= 0;
        end else if (ack) begin
            ack <= 1'b0;
        end else if (req) begin
            if (lat_cnt < lat_cfg) begin
                lat_cnt <= lat_cnt + 1;
            end else begin
                logic [31:0] rd;
                lat_cnt <= 0;
                ack <= 1'b1;
                rd = 32'h0;
                if (!we && addr == BUF_BASE) rd = buf0_init;
                if (!we && addr == CTRL_ADDR) begin
                    rd = (ctrl_rd_n + 1 >= done_thresh) ? 32'h0000_0008 : 32'h0000_0000;
                    ctrl_rd_n <= ctrl_rd_n + 1;
                end
                rdata <= rd;
                if (log_n < 256) begin
                    lg_addr[log_n] <= addr;
                    lg_we[log_n]   <= we;
                    lg_data[log_n] <= we ? wdata : rd;
                    lg_cyc[log_n]  <= cyc;
                    log_n <= log_n + 1;
                end
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic pulse_start(input logic [1:0] c);
        @(negedge clk);
        start = 1'b1;
        code  = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
    endtask

    // Runs one bring-up and checks the full access log against the requirements.
    task automatic run_one(input int c, input logic [31:0] b0, input int d_at, input int lat, input bit poke_busy);
        int base, np, total, pbase;
        bit exp_tmo;
        logic [31:0] exp_ctrl;
        lat_cfg     = lat;
        buf0_init   = b0;
        done_thresh = ctrl_rd_n + d_at;
        base        = log_n;
        np          = (d_at > POLL_LIMIT) ? POLL_LIMIT : d_at;
        exp_tmo     = d_at > POLL_LIMIT;
        total       = 13 + np;
        exp_ctrl    = 32'(c) | (32'hA << 24) | (32'h4 << 28);
        pulse_start(2'(c));
        chk(busy == 1'b1, "R11 busy after start", 32'(busy), 32'h1);
        chk(tmo == 1'b0, "R9 timeout cleared by new start", 32'(tmo), 32'h0);
        if (poke_busy) begin
            repeat (6) @(negedge clk);
            start = 1'b1; code = 2'(c == 3 ? 1 : 3);
            @(negedge clk);
            start = 1'b0;
            start = 1'b0;
            @(negedge clk);
            start = 1'b1; code = 2'd0;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();
        chk(done == 1'b1, "R8 done pulse seen", 32'(done), 32'h1);
        chk(busy == 1'b0, "R11 busy falls with done", 32'(busy), 32'h0);
        chk(tmo == exp_tmo, exp_tmo ? "R9 timeout flag" : "R8 no timeout", 32'(tmo), 32'(exp_tmo));
        @(negedge clk);
        chk(log_n - base == total, "R7 access count", 32'(log_n - base), 32'(total));
        chk(lg_addr[base] == BUF_BASE && !lg_we[base], "R2 first access reads buffer 0", lg_addr[base], BUF_BASE);
        chk(lg_we[base+1] && lg_addr[base+1] == BUF_BASE && lg_data[base+1] == b0 - (32'h1 << (15 + c)),
            "R2 buffer 0 shrunk", lg_data[base+1], b0 - (32'h1 << (15 + c)));
        for (int i = 1; i < 8; i++)
            chk(lg_we[base+1+i] && lg_addr[base+1+i] == BUF_BASE + 32'(4*i) && lg_data[base+1+i] == 0,
                "R3 buffer cleared", lg_addr[base+1+i], BUF_BASE + 32'(4*i));
        chk(lg_addr[base+9] == BKEY_ADDR && lg_data[base+9] == BKEY_VAL, "R4 bucket key first", lg_addr[base+9], BKEY_ADDR);
        chk(lg_addr[base+10] == SKEY_ADDR && lg_data[base+10] == SKEY_VAL, "R4 signature key second", lg_addr[base+10], SKEY_ADDR);
        chk(lg_addr[base+11] == CTRL_ADDR && lg_we[base+11], "R4 control written last", lg_addr[base+11], CTRL_ADDR);
        chk(lg_data[base+11] == exp_ctrl, "R5 control word", lg_data[base+11], exp_ctrl);
        chk(lg_addr[base+12] == FLUSH_ADDR && !lg_we[base+12], "R6 flush read", lg_addr[base+12], FLUSH_ADDR);
        pbase = base + 13;
        for (int j = 0; j < np; j++) begin
            chk(lg_addr[pbase+j] == CTRL_ADDR && !lg_we[pbase+j], "R6 poll reads control", lg_addr[pbase+j], CTRL_ADDR);
            if (j > 0)
                chk(lg_cyc[pbase+j] - lg_cyc[pbase+j-1] >= POLL_CYCLES, "R7 poll spacing",
                    32'(lg_cyc[pbase+j] - lg_cyc[pbase+j-1]), 32'(POLL_CYCLES));
        end
    endtask

    initial begin
        int d0, e0, l0;
        repeat (3) @(negedge clk);
        chk({req, busy, done, tmo, err} == 5'b0, "R12 outputs low in reset", 32'({req, busy, done, tmo, err}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({req, busy, done, tmo, err} == 5'b0, "R12 outputs low after reset", 32'({req, busy, done, tmo, err}), 32'h0);

        // table walk
        for (int v = 0; v < NV; v++)
            run_one(V_CODE[v], V_BUF0[v], V_DONE[v], V_LAT[v], 1'b0);

        // R9: timeout flag persists after the last (timed-out) run
        repeat (5) @(negedge clk);
        chk(tmo == 1'b1, "R9 timeout held", 32'(tmo), 32'h1);

        // R1: rejected code
        l0 = log_n;
        e0 = err_cnt;
        pulse_start(2'd0);
        chk(err == 1'b1, "R1 error pulse", 32'(err), 32'h1);
        chk(busy == 1'b0, "R1 busy stays low", 32'(busy), 32'h0);
        repeat (5) @(negedge clk);
        chk(log_n == l0, "R1 no bus access", 32'(log_n - l0), 32'h0);
        chk(err_cnt == e0 + 1, "R1 single error pulse", 32'(err_cnt - e0), 32'h1);
        chk(tmo == 1'b1, "R1 refused start keeps old timeout", 32'(tmo), 32'h1);

        // R11: starts during busy are ignored (clears old timeout, R9)
        d0 = done_cnt;
        e0 = err_cnt;
        run_one(2, 32'h0010_0000, 2, 1, 1'b1);
        repeat (4) @(negedge clk);
        chk(done_cnt == d0 + 1, "R11 one done per run", 32'(done_cnt - d0), 32'h1);
        chk(err_cnt == e0, "R11 no error from busy start", 32'(err_cnt - e0), 32'h0);
        chk(busy == 1'b0, "R11 stays idle after run", 32'(busy), 32'h0);

        wrap_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        wrap_up();
    end

endmodule